// File: doc/BRIEF.md
# Variable-Group Carry-Skip Adder/Subtractor

This block is a purely combinational N-bit adder that can also subtract. The operand bits are cut into ripple-carry segments whose widths rise by one bit per segment toward the middle of the word and fall again toward the top. Short end segments keep the first and last ripple paths short. Longer middle segments spend their time behind a bypass.

Each segment computes per-bit generate (AND of the operand bits) and propagate (XOR of the operand bits), and ripples a carry through its bits. When every bit of a segment propagates, a two-input multiplexer hands the segment's incoming carry straight to the next segment. Sum bits are the per-bit propagate XOR the carry into that bit.

In subtract mode the second operand is inverted and the carry into bit 0 is forced high, which yields A minus B in two's complement. The carry-out then reads 1 exactly when no borrow occurs. The segment widths form a parameter list, and elaboration stops if they do not add up to the operand width.

Top module: `csk_adder`

## Requirements
- R1: With `sub_en`=0, `{carry_o, sum_o}` equals `op_a + op_b + carry_in` as an (N+1)-bit unsigned value.
- R2: With `sub_en`=1, `sum_o` equals `op_a - op_b` modulo 2^N, and `carry_o` is 1 when `op_a >= op_b` (unsigned) and 0 otherwise.
- R3: With `sub_en`=1, `carry_in` has no effect: both values of `carry_in` give the same `sum_o` and `carry_o`.
- R4: For any segment whose bits all propagate (op_a XOR effective op_b is all ones across the segment), the carry leaving the segment equals the carry entering it. This holds for a 0 and for a 1 arriving from below.
- R5: The default segment widths, listed from the least significant bit upward, are 2, 3, 4, 4, 3, so segments start at bits 0, 2, 5, 9 and 13. A carry generated at bit 0 crosses every fully propagating segment above it and shows up in the sum and carry-out.
- R6: The segment-width list must sum to N. A mismatch is rejected at elaboration.
- R7: With every bit propagating across the whole word, `carry_o` equals the effective carry into bit 0 and `sum_o` is all ones when that carry is 0 and all zeros when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | N | First operand |
| op_b | input | N | Second operand (subtrahend when `sub_en`=1) |
| carry_in | input | 1 | Carry into bit 0 when adding |
| sub_en | input | 1 | 1 selects A minus B |
| sum_o | output | N | Sum or difference |
| carry_o | output | 1 | Carry out of bit N-1 (1 = no borrow when subtracting) |

## Verification
The bench targets each bypass path on its own. For every segment it builds operands where that segment fully propagates, bits below it generate a carry and bits above it are random. A design with a bypass that picked the wrong input or tapped the wrong bit range would drop or invent that carry and corrupt the upper sum bits. Whole-word propagate patterns with both carry values catch a chain that stalls or inverts across all segments. Subtract vectors with equal operands, with zero and with the all-ones word check the borrow sense of `carry_o`. They also catch any leakage of `carry_in` into the subtract path. Seeded random vectors in both modes cover the rest against a behavioural reference.

// File: rtl/csk_pkg.sv
package csk_pkg;

    localparam int unsigned CSK_WIDTH_DEF  = 16;
    localparam int unsigned CSK_GROUPS_DEF = 5;

    typedef struct packed {
        logic prop;
        logic gen;
    } csk_bit_t;

endpackage

// File: rtl/csk_pg.sv
module csk_pg
    import csk_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] prop_o,
    output logic [W-1:0] gen_o
);

    csk_bit_t [W-1:0] bit_d;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            bit_d[i].prop = a_i[i] ^ b_i[i];
            bit_d[i].gen  = a_i[i] & b_i[i];
        end
        assign prop_o[i] = bit_d[i].prop;
        assign gen_o[i]  = bit_d[i].gen;
    end

endmodule

// File: rtl/csk_group.sv
module csk_group #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] prop_i,
    input  logic [W-1:0] gen_i,
    input  logic         cin_i,
    output logic [W-1:0] bit_c_o,
    output logic         cout_o
);

    logic [W:0] chain_d;
    logic       seg_prop_d;
    logic       ripple_out_d;

    always_comb begin
        chain_d[0] = cin_i;
        for (int i = 0; i < int'(W); i++) begin
            chain_d[i+1] = gen_i[i] | (prop_i[i] & chain_d[i]);
        end
        ripple_out_d = chain_d[W];
        seg_prop_d   = &prop_i;
    end

    assign bit_c_o = chain_d[W-1:0];
    assign cout_o  = seg_prop_d ? cin_i : ripple_out_d;

    always_comb begin
        if (!$isunknown({prop_i, gen_i, cin_i})) begin
            p_bypass_matches_ripple_r4: assert (cout_o == ripple_out_d)
                else $error("bypass carry differs from rippled carry");
            if (seg_prop_d) begin
                p_prop_ripple_passes_cin_r4: assert (ripple_out_d == cin_i)
                    else $error("fully propagating segment altered its carry");
            end
        end
    end

endmodule

// File: rtl/csk_adder.sv
module csk_adder
    import csk_pkg::*;
#(
    parameter int unsigned N          = CSK_WIDTH_DEF,
    parameter int unsigned NUM_GROUPS = CSK_GROUPS_DEF,
    parameter int unsigned GROUP_W [NUM_GROUPS] = '{2, 3, 4, 4, 3}
) (
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    input  logic         carry_in,
    input  logic         sub_en,
    output logic [N-1:0] sum_o,
    output logic         carry_o
);

    function automatic int unsigned seg_base(int unsigned idx);
        int unsigned acc = 0;
        for (int unsigned k = 0; k < idx; k++) acc += GROUP_W[k];
        return acc;
    endfunction

    localparam int unsigned TOTAL_W = seg_base(NUM_GROUPS);

    if (TOTAL_W != N) begin : g_width_check_r6
        $error("segment widths sum to %0d, operand width is %0d", TOTAL_W, N);
    end

    logic [N-1:0]          b_eff_d;
    logic                  cin_eff_d;
    logic [N-1:0]          prop_d;
    logic [N-1:0]          gen_d;
    logic [N-1:0]          bit_c_d;
    logic [NUM_GROUPS:0]   seg_c_d;

    always_comb begin
        b_eff_d   = sub_en ? ~op_b : op_b;
        cin_eff_d = sub_en | carry_in;
    end

    csk_pg #(.W(N)) u_pg (
        .a_i   (op_a),
        .b_i   (b_eff_d),
        .prop_o(prop_d),
        .gen_o (gen_d)
    );

    assign seg_c_d[0] = cin_eff_d;

    for (genvar s = 0; s < NUM_GROUPS; s++) begin : g_seg
        localparam int unsigned BASE = seg_base(s);
        localparam int unsigned SW   = GROUP_W[s];
        csk_group #(.W(SW)) u_group (
            .prop_i (prop_d[BASE +: SW]),
            .gen_i  (gen_d[BASE +: SW]),
            .cin_i  (seg_c_d[s]),
            .bit_c_o(bit_c_d[BASE +: SW]),
            .cout_o (seg_c_d[s+1])
        );
    end

    assign sum_o   = prop_d ^ bit_c_d;
    assign carry_o = seg_c_d[NUM_GROUPS];

    always_comb begin
        if (!$isunknown({op_a, op_b, carry_in, sub_en})) begin
            if (!sub_en) begin
                p_add_result_r1: assert ({carry_o, sum_o} ==
                        ({1'b0, op_a} + {1'b0, op_b} + {{N{1'b0}}, carry_in}))
                    else $error("sum mismatch in add mode");
            end else begin
                p_sub_result_r2: assert (sum_o == N'(op_a - op_b)
                                         && carry_o == (op_a >= op_b))
                    else $error("difference or borrow mismatch");
            end
            if (&prop_d) begin
                p_word_propagate_r7: assert (carry_o == cin_eff_d
                                             && sum_o == {N{~cin_eff_d}})
                    else $error("whole-word propagate result wrong");
            end
        end
    end

endmodule

// File: tb/tb_csk_adder.sv
module tb_csk_adder;

    localparam int N = 16;

    logic         clk = 1'b0;
    logic [N-1:0] op_a = '0;
    logic [N-1:0] op_b = '0;
    logic         carry_in = 1'b0;
    logic         sub_en = 1'b0;
    logic [N-1:0] sum_o;
    logic         carry_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    csk_adder dut (
        .op_a    (op_a),
        .op_b    (op_b),
        .carry_in(carry_in),
        .sub_en  (sub_en),
        .sum_o   (sum_o),
        .carry_o (carry_o)
    );

    function automatic logic [N:0] ref_result(logic [N-1:0] a, logic [N-1:0] b,
                                              logic ci, logic sb);
        logic [N:0] r;
        if (sb) begin
            r[N-1:0] = a - b;
            r[N]     = (a >= b);
        end else begin
            r = {1'b0, a} + {1'b0, b} + {{N{1'b0}}, ci};
        end
        return r;
    endfunction

    task automatic apply_check(input logic [N-1:0] a, input logic [N-1:0] b,
                               input logic ci, input logic sb, input string req);
        logic [N:0] exp;
        @(posedge clk);
        op_a = a; op_b = b; carry_in = ci; sub_en = sb;
        @(negedge clk);
        exp = ref_result(a, b, ci, sb);
        checks++;
        if ({carry_o, sum_o} !== exp) begin
            failures++;
            $display("FAIL %s a=%h b=%h ci=%0b sub=%0b actual=%0b_%h expected=%0b_%h",
                     req, a, b, ci, sb, carry_o, sum_o, exp[N], exp[N-1:0]);
        end
    endtask

    task automatic expect_out(input logic [N:0] exp, input string req);
        checks++;
        if ({carry_o, sum_o} !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b_%h expected=%0b_%h",
                     req, carry_o, sum_o, exp[N], exp[N-1:0]);
        end
    endtask

    initial begin
        int unsigned seed_v;
        int seg_w [5] = '{2, 3, 4, 4, 3};
        int seg_b [5] = '{0, 2, 5, 9, 13};
        logic [N-1:0] ra, rb, mask, below, r0, r1;
        logic         k0, k1;
        seed_v = $urandom(32'h5eed_0417);

        // reset state: all-zero inputs
        apply_check('0, '0, 1'b0, 1'b0, "R1 zero");
        expect_out('0, "R1 zero literal");

        // R7: whole-word propagate, both carry values
        apply_check(16'hA5C3, 16'h5A3C, 1'b0, 1'b0, "R7 prop cin0");
        expect_out({1'b0, 16'hFFFF}, "R7 prop cin0 literal");
        apply_check(16'hA5C3, 16'h5A3C, 1'b1, 1'b0, "R7 prop cin1");
        expect_out({1'b1, 16'h0000}, "R7 prop cin1 literal");
        apply_check(16'hFFFF, 16'h0000, 1'b1, 1'b0, "R7 full chain");

        // R5 / R4: each segment fully propagates, carry generated below
        for (int s = 0; s < 5; s++) begin
            for (int ci = 0; ci < 2; ci++) begin
                mask  = N'(((1 << seg_w[s]) - 1) << seg_b[s]);
                below = N'((1 << seg_b[s]) - 1);
                ra = N'($urandom);
                rb = N'($urandom);
                ra = (ra & ~mask & ~below) | (ra & mask) | below;
                rb = (rb & ~mask & ~below) | (~ra & mask) | (below & {N{ci[0]}});
                apply_check(ra, rb, ~ci[0], 1'b0, "R4 R5 segment bypass");
            end
        end

        // R2: subtract corners
        apply_check(16'h1234, 16'h1234, 1'b0, 1'b1, "R2 equal");
        expect_out({1'b1, 16'h0000}, "R2 equal literal");
        apply_check(16'h0000, 16'h0001, 1'b0, 1'b1, "R2 borrow");
        expect_out({1'b0, 16'hFFFF}, "R2 borrow literal");
        apply_check(16'hFFFF, 16'h0000, 1'b1, 1'b1, "R2 max minus zero");
        apply_check(16'h0000, 16'hFFFF, 1'b0, 1'b1, "R2 zero minus max");

        // R3: carry_in ignored when subtracting
        for (int i = 0; i < 20; i++) begin
            ra = N'($urandom); rb = N'($urandom);
            @(posedge clk); op_a = ra; op_b = rb; carry_in = 1'b0; sub_en = 1'b1;
            @(negedge clk); r0 = sum_o; k0 = carry_o;
            @(posedge clk); carry_in = 1'b1;
            @(negedge clk); r1 = sum_o; k1 = carry_o;
            checks++;
            if ({k1, r1} !== {k0, r0}) begin
                failures++;
                $display("FAIL R3 carry_in leak actual=%0b_%h expected=%0b_%h",
                         k1, r1, k0, r0);
            end
        end

        // R1 / R2: seeded random in both modes
        for (int i = 0; i < 400; i++) begin
            ra = N'($urandom); rb = N'($urandom);
            apply_check(ra, rb, 1'($urandom), 1'b0, "R1 random add");
            apply_check(ra, rb, 1'($urandom), 1'b1, "R2 random sub");
        end

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule